// File: doc/BRIEF.md
# Dual-Width Programmable Pulse Generator

This block makes pulse-width-modulated or single-shot pulses from a down-counter. Software sets a cycle length and a duty point through a small register write port. When a channel starts, or later reloads, it copies both values into working registers and loads the counter with the cycle value. The output goes high at each load and goes low when the counter reaches the duty value. Each counter-clock tick lowers the count by one. When a tick arrives with the counter at zero, a borrow occurs. After a borrow, the channel reloads in continuous mode, or stops with its output low in one-shot mode.

The counter advances on a tick. The tick comes from a free-running prescaler that divides the block clock by 1, 4, 16 or 64, or from an external reload-timer underflow pulse. A split bit turns the unit into two independent 8-bit generators that share the tick. A channel starts on a software start write or, if enabled, on an external trigger pulse. Each borrow raises a one-clock strobe meant to start an A/D conversion. Three events per channel (start, borrow, duty match) set sticky flags. Software clears a flag by writing 1 to it. The flags combine with enable bits into one interrupt request.

All pins are plain control and status signals: the register port is a one-cycle write strobe with no back-pressure, and there is no streaming interface.

Top module: `pulse_gen`

## Requirements
- R1: While rst_n is low, and right after it is released, pulse_o, adc_start_o, irq_o and irq_flags_o are all zero. The prescaler count is zero.
- R2: The control register is written at address 0. Its fields are bit0 enable, bit1 one-shot, bits3:2 divider select, bit4 external clock, bit5 split and bit6 external-trigger enable. A 6-bit prescaler counts every clock from reset. With bit4 clear, a tick occurs when the low 2·sel bits of that count are all ones, which gives divide by 1, 4, 16 or 64 for sel = 0 to 3. With bit4 set, each clock in which tmr_uflow_i is high is a tick.
- R3: Cycle is written at address 1 and duty at address 2. At each load or reload, the output is high unless duty is 0 or duty equals cycle. When a tick takes the count to the duty value, the output goes low. If duty is greater than cycle, the output stays high. The period is cycle+1 ticks.
- R4: In one-shot mode (bit1), a borrow stops the channel with its output low. A later start runs it again.
- R5: A write to address 3 with data bit0 starts channel 0, and with data bit1 starts channel 1. hw_trig_i starts every enabled channel when bit6 is set. A start is ignored while the channel runs or while it is disabled. Clearing enable stops the channel at the next clock and forces its output low.
- R6: adc_start_o is high for the clock after each edge at which any channel borrows.
- R7: Flag bits are {ch1 duty, ch1 borrow, ch1 start, ch0 duty, ch0 borrow, ch0 start}, in order from bit 5 to bit 0. A flag is set at the edge where its event occurs. Writing 1 to a bit at address 4 clears that flag. If a set and a clear happen at the same edge, the set wins.
- R8: Interrupt enables are written to data bits 5:0 at address 5. irq_o is high exactly when some flag and its enable are both set.
- R9: With split set, channel 0 uses bits 7:0 of cycle and duty, and channel 1 uses bits 15:8. Both channels run independently on the same tick. With split clear, channel 1 is disabled and its output is low.
- R10: A write to cycle or duty while a channel runs does not change the current period. The new values take effect at the next reload or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| hw_trig_i | input | 1 | External start trigger pulse |
| tmr_uflow_i | input | 1 | Reload-timer underflow pulse, used as tick source |
| pulse_o | output | 2 | Pulse outputs, bit 1 used only in split mode |
| adc_start_o | output | 1 | One-clock conversion start strobe |
| irq_o | output | 1 | Combined interrupt request |
| irq_flags_o | output | 6 | Sticky event flags |

## Verification
Start writes, control writes and external triggers act at the rising edge that samples them. The pulse, the flags and the conversion strobe from that edge are visible right after it. irq_o follows the flags with no further delay. Borrows and duty matches happen at the edge that consumes a tick, and the tick is decided from the prescaler count held before that edge. The bench's reference model applies the same sampled inputs at every rising edge and compares all outputs at the falling edge, half a period later, so each result is read in the cycle it is due.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int CNT_W  = 16;
  localparam int HALF_W = CNT_W / 2;
  localparam int NCH    = 2;
  localparam int EV_N   = 3;
  localparam int FLAG_W = EV_N * NCH;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 6;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CYCLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_DUTY  = 3'd2;
  localparam logic [ADDR_W-1:0] A_START = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd4;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd5;

  typedef enum logic [1:0] {DIV1 = 2'd0, DIV4 = 2'd1, DIV16 = 2'd2, DIV64 = 2'd3} div_e;

  typedef struct packed {
    logic hw_trig_en;
    logic split;
    logic ext_clk;
    div_e div;
    logic one_shot;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pg_regs.sv
module pg_regs
  import pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cycle_o,
  output logic [CNT_W-1:0]  duty_o,
  output logic [FLAG_W-1:0] ien_o,
  output logic [NCH-1:0]    sw_start_o,
  output logic [FLAG_W-1:0] clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      cycle_o <= '0;
      duty_o  <= '0;
      ien_o   <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL:  ctrl_o  <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        A_CYCLE: cycle_o <= wr_data_i;
        A_DUTY:  duty_o  <= wr_data_i;
        A_IEN:   ien_o   <= wr_data_i[FLAG_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    sw_start_o = '0;
    clr_o      = '0;
    if (wr_en_i && wr_addr_i == A_START) sw_start_o = wr_data_i[NCH-1:0];
    if (wr_en_i && wr_addr_i == A_CLR)   clr_o      = wr_data_i[FLAG_W-1:0];
  end
endmodule

// File: rtl/pg_presc.sv
module pg_presc
  import pg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  div_e div_i,
  input  logic ext_i,
  input  logic ext_tick_i,
  output logic tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    case (div_i)
      DIV1:    mask = '0;
      DIV4:    mask = PRE_W'(3);
      DIV16:   mask = PRE_W'(15);
      default: mask = PRE_W'(63);
    endcase
  end

  assign tick_o = ext_i ? ext_tick_i : ((pre_q & mask) == mask);
endmodule

// File: rtl/pg_chan.sv
module pg_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         one_shot_i,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic [W-1:0] cycle_i,
  input  logic [W-1:0] duty_i,
  output logic         out_o,
  output logic         trig_ev_o,
  output logic         borrow_ev_o,
  output logic         duty_ev_o
);
  logic         run_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] duty_q;
  logic [W-1:0] cnt_dec;
  logic         step;
  logic         at_zero;
  logic         load_hi;

  assign cnt_dec     = cnt_q - W'(1);
  assign step        = en_i && run_q && tick_i;
  assign at_zero     = (cnt_q == '0);
  assign load_hi     = (duty_i != '0) && (duty_i != cycle_i);
  assign trig_ev_o   = en_i && start_i && !run_q;
  assign borrow_ev_o = step && at_zero;
  assign duty_ev_o   = (trig_ev_o && duty_i == cycle_i)
                     || (borrow_ev_o && !one_shot_i && duty_i == cycle_i)
                     || (step && !at_zero && cnt_dec == duty_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      duty_q <= '0;
      out_o  <= 1'b0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      out_o <= 1'b0;
    end else if (trig_ev_o) begin
      run_q  <= 1'b1;
      cnt_q  <= cycle_i;
      duty_q <= duty_i;
      out_o  <= load_hi;
    end else if (step) begin
      if (at_zero) begin
        if (one_shot_i) begin
          run_q <= 1'b0;
          out_o <= 1'b0;
        end else begin
          cnt_q  <= cycle_i;
          duty_q <= duty_i;
          out_o  <= load_hi;
        end
      end else begin
        cnt_q <= cnt_dec;
        if (cnt_dec == duty_q) out_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pg_irq.sv
module pg_irq
  import pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic [FLAG_W-1:0] ien_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= (flags_o & ~clr_i) | set_i;
  end

  assign irq_o = |(flags_o & ien_i);
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
  import pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              hw_trig_i,
  input  logic              tmr_uflow_i,
  output logic [NCH-1:0]    pulse_o,
  output logic              adc_start_o,
  output logic              irq_o,
  output logic [FLAG_W-1:0] irq_flags_o
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cycle_q, duty_q;
  logic [FLAG_W-1:0] ien_q, clr, set;
  logic [NCH-1:0]    sw_start, start, trig_ev, borrow_ev, duty_ev;
  logic              tick;

  pg_regs u_regs (
    .clk, .rst_n, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl_q), .cycle_o(cycle_q), .duty_o(duty_q), .ien_o(ien_q),
    .sw_start_o(sw_start), .clr_o(clr)
  );

  pg_presc u_presc (
    .clk, .rst_n, .div_i(ctrl_q.div), .ext_i(ctrl_q.ext_clk),
    .ext_tick_i(tmr_uflow_i), .tick_o(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign start[g] = sw_start[g] || (hw_trig_i && ctrl_q.hw_trig_en);
    assign set[EV_N*g+0] = trig_ev[g];
    assign set[EV_N*g+1] = borrow_ev[g];
    assign set[EV_N*g+2] = duty_ev[g];
    if (g == 0) begin : g_wide
      logic [CNT_W-1:0] cyc0, duty0;
      assign cyc0  = ctrl_q.split ? {{HALF_W{1'b0}}, cycle_q[HALF_W-1:0]} : cycle_q;
      assign duty0 = ctrl_q.split ? {{HALF_W{1'b0}}, duty_q[HALF_W-1:0]}  : duty_q;
      pg_chan #(.W(CNT_W)) u_chan (
        .clk, .rst_n, .en_i(ctrl_q.en), .one_shot_i(ctrl_q.one_shot),
        .tick_i(tick), .start_i(start[g]), .cycle_i(cyc0), .duty_i(duty0),
        .out_o(pulse_o[g]), .trig_ev_o(trig_ev[g]),
        .borrow_ev_o(borrow_ev[g]), .duty_ev_o(duty_ev[g])
      );
    end else begin : g_narrow
      pg_chan #(.W(HALF_W)) u_chan (
        .clk, .rst_n, .en_i(ctrl_q.en && ctrl_q.split), .one_shot_i(ctrl_q.one_shot),
        .tick_i(tick), .start_i(start[g]),
        .cycle_i(cycle_q[CNT_W-1:HALF_W]), .duty_i(duty_q[CNT_W-1:HALF_W]),
        .out_o(pulse_o[g]), .trig_ev_o(trig_ev[g]),
        .borrow_ev_o(borrow_ev[g]), .duty_ev_o(duty_ev[g])
      );
    end
  end

  pg_irq u_irq (
    .clk, .rst_n, .set_i(set), .clr_i(clr), .ien_i(ien_q),
    .flags_o(irq_flags_o), .irq_o
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adc_start_o <= 1'b0;
    else        adc_start_o <= |borrow_ev;
  end
endmodule

// File: rtl/pg_checker.sv
module pg_checker
  import pg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              split,
  input logic              trig0,
  input logic [NCH-1:0]    pulse_o,
  input logic              adc_start_o,
  input logic              irq_o,
  input logic [FLAG_W-1:0] irq_flags_o
);
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (pulse_o == '0)); // R5
  AST_CH1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && !$past(split)) |-> !pulse_o[1]); // R9
  AST_ADC_HAS_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |-> (irq_flags_o[1] || irq_flags_o[4])); // R6
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_flags_o != '0)); // R8
  AST_START_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    trig0 |=> irq_flags_o[0]); // R7
endmodule

bind pulse_gen pg_checker u_pg_checker (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .split(ctrl_q.split),
  .trig0(trig_ev[0]), .pulse_o(pulse_o), .adc_start_o(adc_start_o),
  .irq_o(irq_o), .irq_flags_o(irq_flags_o)
);

// File: tb/pulse_gen_bench.sv
`timescale 1ns/1ps
module pulse_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        hw_trig = 1'b0;
  logic        tmr_uf = 1'b0;
  logic [1:0]  pulse;
  logic        adc;
  logic        irq;
  logic [5:0]  flags;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string cur = "R1";

  always #2 clk = ~clk;

  pulse_gen u_pulse_gen (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hw_trig_i(hw_trig), .tmr_uflow_i(tmr_uf),
    .pulse_o(pulse), .adc_start_o(adc), .irq_o(irq), .irq_flags_o(flags)
  );

  // behavioural reference model
  int m_pre, m_ctrl, m_cyc, m_duty, m_ien, m_flags, m_adc;
  int m_run[2], m_cnt[2], m_dq[2], m_out[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_ctrl = 0; m_cyc = 0; m_duty = 0; m_ien = 0; m_flags = 0; m_adc = 0;
      for (int c = 0; c < 2; c++) begin m_run[c] = 0; m_cnt[c] = 0; m_dq[c] = 0; m_out[c] = 0; end
    end else begin
      int en, os, dv, ext, sp, hw, mask, tick, sw, setv, clrv, bor, ce, cy, du, st;
      en = m_ctrl & 1; os = (m_ctrl >> 1) & 1; dv = (m_ctrl >> 2) & 3;
      ext = (m_ctrl >> 4) & 1; sp = (m_ctrl >> 5) & 1; hw = (m_ctrl >> 6) & 1;
      mask = (1 << (2 * dv)) - 1;
      tick = ext ? int'(tmr_uf) : int'((m_pre & mask) == mask);
      m_pre = (m_pre + 1) % 64;
      sw = (wr_en && wr_addr == 3) ? int'(wr_data[1:0]) : 0;
      clrv = (wr_en && wr_addr == 4) ? int'(wr_data[5:0]) : 0;
      setv = 0; bor = 0;
      for (int c = 0; c < 2; c++) begin
        ce = (c == 1) ? (en & sp) : en;
        cy = (c == 1) ? (m_cyc >> 8) : (sp ? (m_cyc & 255) : m_cyc);
        du = (c == 1) ? (m_duty >> 8) : (sp ? (m_duty & 255) : m_duty);
        st = ((sw >> c) & 1) | (int'(hw_trig) & hw);
        if (!ce) begin
          m_run[c] = 0; m_out[c] = 0;
        end else if (st && !m_run[c]) begin
          m_run[c] = 1; m_cnt[c] = cy; m_dq[c] = du;
          m_out[c] = (du != 0 && du != cy);
          setv |= 1 << (3 * c);
          if (du == cy) setv |= 4 << (3 * c);
        end else if (m_run[c] && tick) begin
          if (m_cnt[c] == 0) begin
            setv |= 2 << (3 * c); bor = 1;
            if (os) begin m_run[c] = 0; m_out[c] = 0; end
            else begin
              m_cnt[c] = cy; m_dq[c] = du; m_out[c] = (du != 0 && du != cy);
              if (du == cy) setv |= 4 << (3 * c);
            end
          end else begin
            m_cnt[c] = m_cnt[c] - 1;
            if (m_cnt[c] == m_dq[c]) begin m_out[c] = 0; setv |= 4 << (3 * c); end
          end
        end
      end
      m_flags = (m_flags & ~clrv & 63) | setv;
      m_adc = bor;
      if (wr_en) case (wr_addr)
        3'd0: m_ctrl = int'(wr_data[6:0]);
        3'd1: m_cyc  = int'(wr_data);
        3'd2: m_duty = int'(wr_data);
        3'd5: m_ien  = int'(wr_data[5:0]);
        default: ;
      endcase
    end
  end

  task automatic check(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", cur, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check("pulse", int'(pulse), (m_out[1] << 1) | m_out[0]);
    check("adc_start", int'(adc), m_adc);
    check("flags", int'(flags), m_flags);
    check("irq", int'(irq), int'((m_flags & m_ien) != 0));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_in(input bit trig);
    @(negedge clk); #1;
    if (trig) hw_trig = 1'b1; else tmr_uf = 1'b1;
    @(negedge clk); #1;
    hw_trig = 1'b0; tmr_uf = 1'b0;
  endtask

  function automatic int mk(input int en, input int os, input int dv, input int ext,
                            input int sp, input int hw);
    return en | (os << 1) | (dv << 2) | (ext << 4) | (sp << 5) | (hw << 6);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    cur = "R1"; idle(4); #1 rst_n = 1'b1; idle(3);
    cur = "R3"; wr(5, 'h3f); wr(1, 5); wr(2, 2); wr(0, mk(1,0,0,0,0,0)); wr(3, 1); idle(30);
    cur = "R10"; wr(1, 3); wr(2, 1); idle(25);
    cur = "R3"; wr(2, 0); idle(15); wr(2, 9); idle(15); wr(2, 3); idle(15);
    cur = "R2"; wr(2, 1); wr(1, 4); wr(0, mk(1,0,1,0,0,0)); idle(60);
    wr(0, mk(1,0,2,0,0,0)); idle(200); wr(0, mk(1,0,3,0,0,0)); idle(400);
    wr(0, mk(1,0,0,1,0,0));
    for (int i = 0; i < 12; i++) begin pulse_in(0); idle(i % 3); end
    cur = "R4"; wr(0, 0); wr(1, 6); wr(2, 2); wr(0, mk(1,1,0,0,0,0)); wr(3, 1); idle(15);
    wr(3, 1); idle(15);
    cur = "R5"; wr(0, mk(1,0,0,0,0,1)); pulse_in(1); idle(4); pulse_in(1); idle(10);
    wr(3, 1); idle(3); wr(0, 0); idle(4); wr(3, 1); pulse_in(1); idle(4);
    cur = "R7"; wr(4, 'h3f); idle(3); wr(0, mk(1,0,0,0,0,0)); wr(3, 1); idle(4); wr(4, 'h07); idle(6);
    cur = "R8"; wr(5, 0); idle(8); wr(5, 'h02); idle(20); wr(4, 'h3f); wr(5, 'h04); idle(10);
    cur = "R6"; wr(0, 0); wr(1, 0); wr(2, 0); wr(0, mk(1,0,0,0,0,0)); wr(3, 1); idle(6);
    wr(1, 2); wr(2, 1); idle(12);
    cur = "R9"; wr(0, 0); wr(5, 'h3f); wr(1, (5 << 8) | 3); wr(2, (2 << 8) | 1);
    wr(0, mk(1,0,0,0,1,0)); wr(3, 1); idle(3); wr(3, 2); idle(30); wr(3, 3); idle(10);
    wr(0, mk(1,0,0,0,0,0)); idle(10);
    finish_run();
  end
endmodule